// File: doc/BRIEF.md
# Integer ALU with Signed-Overflow Trap

This block is the arithmetic and logic unit of a simple load-store integer core. It is purely combinational: two data operands, a shift distance and a 4-bit operation code go in, and a data result plus an overflow trap flag come out in the same cycle. Operand preparation (immediate sign or zero extension, choosing a register or an immediate for operand B) is done by the surrounding datapath. The ALU sees only ready-made operands.

The unit covers addition and subtraction in trapping (signed) and wrapping (unsigned) forms, the four bitwise operations including NOR, three barrel shifts and a load-upper-immediate operation. The trap flag is the only exception output. Cancelling the register write and redirecting the program counter are left to the pipeline control that reads the flag.

Top module: `int_alu`

## Requirements
- R1: Opcodes 0 (ADD) and 1 (ADDU) return the low DATA_W bits of opd_a + opd_b.
- R2: Opcodes 2 (SUB) and 3 (SUBU) return the low DATA_W bits of opd_a - opd_b.
- R3: For ADD, ovf_trap is 1 exactly when the two's-complement sum of opd_a and opd_b is outside the signed DATA_W range.
- R4: For SUB, ovf_trap is 1 exactly when the two's-complement difference opd_a - opd_b is outside the signed DATA_W range.
- R5: ADDU and SUBU never raise ovf_trap, even when the unsigned result wraps.
- R6: Opcodes 4, 5, 6 and 7 return the bitwise AND, OR, XOR and NOR of opd_a and opd_b.
- R7: Opcode 8 (SLL) returns opd_b shifted left by sh_amt, with zeros entering at bit 0.
- R8: Opcode 9 (SRL) returns opd_b shifted right by sh_amt, with zeros entering at the top bit.
- R9: Opcode 10 (SRA) returns opd_b shifted right by sh_amt, with copies of opd_b's top bit entering at the top.
- R10: Opcode 11 (LUI) returns opd_b[DATA_W/2-1:0] in the upper half of the result and zeros in the lower half. opd_a and sh_amt have no effect on it.
- R11: ovf_trap is 0 for every opcode other than ADD and SUB.
- R12: Opcodes 12 to 15 are unassigned and return a zero result with ovf_trap 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | DATA_W | First operand (minuend and augend) |
| opd_b | input | DATA_W | Second operand; also the shift source and the immediate for LUI |
| sh_amt | input | $clog2(DATA_W) | Shift distance for SLL, SRL and SRA |
| op_sel | input | 4 | Operation code |
| result | output | DATA_W | Operation result |
| ovf_trap | output | 1 | Signed overflow on ADD or SUB |

## Verification
The block has no stored state, so any fault shows at the ports in the same evaluation in which the faulty operation is selected. A wrong carry-in or operand inversion gives an off-by-one or complemented sum. A wrong trap condition shows only on operands that sit at the signed boundaries. A miswired shifter stage corrupts the result only for distances that set that stage's bit. For these reasons the directed cases concentrate on sign-boundary operands and on shift distances of 0, 1, powers of two and the maximum.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int XLEN = 32;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_SRA  = 4'd10,
        OP_LUI  = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_fn_e;

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
    parameter int DATA_W = int_alu_pkg::XLEN
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              trap_en_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              ovf_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff_d;
    logic [DATA_W:0]   full_d;

    always_comb begin
        b_eff_d = sub_i ? ~b_i : b_i;
        full_d  = {1'b0, a_i} + {1'b0, b_eff_d} + {{DATA_W{1'b0}}, sub_i};
        sum_o   = full_d[DATA_W-1:0];
        ovf_o   = trap_en_i
                & (a_i[MSB] == b_eff_d[MSB])
                & (full_d[MSB] != a_i[MSB]);
    end

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
    parameter int DATA_W = int_alu_pkg::XLEN
) (
    input  logic [DATA_W-1:0]            a_i,
    input  logic [DATA_W-1:0]            b_i,
    input  int_alu_pkg::logic_fn_e       fn_i,
    output logic [DATA_W-1:0]            y_o
);
    import int_alu_pkg::*;

    always_comb begin
        unique case (fn_i)
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            LG_XOR:  y_o = a_i ^ b_i;
            LG_NOR:  y_o = ~(a_i | b_i);
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
    parameter int DATA_W = int_alu_pkg::XLEN,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [SH_W-1:0]   dist_i,
    input  logic              left_i,
    input  logic              arith_i,
    output logic [DATA_W-1:0] y_o
);
    logic [DATA_W-1:0] src_d;
    logic              fill_d;
    logic [DATA_W-1:0] stg [SH_W+1];

    // Left shifts reuse the right shifter on a bit-reversed operand.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            src_d[i] = left_i ? val_i[DATA_W-1-i] : val_i[i];
        end
        fill_d = arith_i & ~left_i & val_i[DATA_W-1];
    end

    assign stg[0] = src_d;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stg[s+1] = dist_i[s]
                        ? {{STEP{fill_d}}, stg[s][DATA_W-1:STEP]}
                        : stg[s];
    end

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            y_o[i] = left_i ? stg[SH_W][DATA_W-1-i] : stg[SH_W][i];
        end
    end

endmodule

// File: rtl/int_alu.sv
module int_alu #(
    parameter int DATA_W = int_alu_pkg::XLEN,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int IMM_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0]             opd_a,
    input  logic [DATA_W-1:0]             opd_b,
    input  logic [SH_W-1:0]               sh_amt,
    input  logic [int_alu_pkg::OP_W-1:0]  op_sel,
    output logic [DATA_W-1:0]             result,
    output logic                          ovf_trap
);
    import int_alu_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              ovf;
    } alu_out_t;

    alu_op_e           op_d;
    logic              sub_d;
    logic              trap_en_d;
    logic              left_d;
    logic              arith_d;
    logic_fn_e         fn_d;
    logic [DATA_W-1:0] sum_d;
    logic              add_ovf_d;
    logic [DATA_W-1:0] lg_d;
    logic [DATA_W-1:0] sh_d;
    alu_out_t          out_d;

    always_comb begin
        op_d      = alu_op_e'(op_sel);
        sub_d     = (op_d == OP_SUB) | (op_d == OP_SUBU);
        trap_en_d = (op_d == OP_ADD) | (op_d == OP_SUB);
        left_d    = (op_d == OP_SLL);
        arith_d   = (op_d == OP_SRA);
        fn_d      = logic_fn_e'(op_sel[1:0]);
    end

    int_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i       (opd_a),
        .b_i       (opd_b),
        .sub_i     (sub_d),
        .trap_en_i (trap_en_d),
        .sum_o     (sum_d),
        .ovf_o     (add_ovf_d)
    );

    int_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a_i  (opd_a),
        .b_i  (opd_b),
        .fn_i (fn_d),
        .y_o  (lg_d)
    );

    int_alu_shift #(.DATA_W(DATA_W)) u_shift (
        .val_i   (opd_b),
        .dist_i  (sh_amt),
        .left_i  (left_d),
        .arith_i (arith_d),
        .y_o     (sh_d)
    );

    always_comb begin
        out_d = '0;
        case (op_d)
            OP_ADD, OP_SUB: begin
                out_d.res = sum_d;
                out_d.ovf = add_ovf_d;
            end
            OP_ADDU, OP_SUBU:              out_d.res = sum_d;
            OP_AND, OP_OR, OP_XOR, OP_NOR: out_d.res = lg_d;
            OP_SLL, OP_SRL, OP_SRA:        out_d.res = sh_d;
            OP_LUI:                        out_d.res = {opd_b[IMM_W-1:0], {(DATA_W-IMM_W){1'b0}}};
            default:                       out_d = '0;
        endcase
    end

    assign result   = out_d.res;
    assign ovf_trap = out_d.ovf;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
    parameter int DATA_W = int_alu_pkg::XLEN,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int IMM_W = DATA_W / 2
) (
    input logic [DATA_W-1:0]             opd_a,
    input logic [DATA_W-1:0]             opd_b,
    input logic [SH_W-1:0]               sh_amt,
    input logic [int_alu_pkg::OP_W-1:0]  op_sel,
    input logic [DATA_W-1:0]             result,
    input logic                          ovf_trap
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] low_mask;

    always_comb begin
        low_mask = ~({DATA_W{1'b1}} << sh_amt);
        if (!$isunknown({op_sel, opd_a, opd_b, sh_amt})) begin
            if (op_sel == 4'd0 || op_sel == 4'd1)
                p_add_inverse_r1: assert (result - opd_b == opd_a);
            if (op_sel == 4'd2 || op_sel == 4'd3)
                p_sub_inverse_r2: assert (result + opd_b == opd_a);
            if (op_sel == 4'd0 && ovf_trap)
                p_add_ovf_sign_r3: assert (opd_a[MSB] == opd_b[MSB] && result[MSB] != opd_a[MSB]);
            if (op_sel == 4'd2 && ovf_trap)
                p_sub_ovf_sign_r4: assert (opd_a[MSB] != opd_b[MSB] && result[MSB] != opd_a[MSB]);
            if (op_sel == 4'd1 || op_sel == 4'd3)
                p_no_overflow_r5: assert (!ovf_trap);
            if (op_sel == 4'd8)
                p_sll_zero_low_r7: assert ((result & low_mask) == '0);
            if (op_sel == 4'd10)
                p_sra_sign_keep_r9: assert (result[MSB] == opd_b[MSB]);
            if (op_sel == 4'd11)
                p_lui_low_clear_r10: assert (result[IMM_W-1:0] == '0);
            if (op_sel != 4'd0 && op_sel != 4'd2)
                p_trap_only_signed_r11: assert (!ovf_trap);
            if (op_sel >= 4'd12)
                p_unused_zero_r12: assert (result == '0);
        end
    end

endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .opd_a    (opd_a),
    .opd_b    (opd_b),
    .sh_amt   (sh_amt),
    .op_sel   (op_sel),
    .result   (result),
    .ovf_trap (ovf_trap)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int SW         = 5;
    localparam int WATCHDOG   = 50000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] opd_a = '0;
    logic [DW-1:0] opd_b = '0;
    logic [SW-1:0] sh_amt = '0;
    logic [3:0]    op_sel = '0;
    logic [DW-1:0] result;
    logic          ovf_trap;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_alu u_int_alu (
        .opd_a    (opd_a),
        .opd_b    (opd_b),
        .sh_amt   (sh_amt),
        .op_sel   (op_sel),
        .result   (result),
        .ovf_trap (ovf_trap)
    );

    // Independent reference built from the requirement text.
    function automatic logic [DW:0] model(input logic [3:0] op, input logic [DW-1:0] a,
                                          input logic [DW-1:0] b, input logic [SW-1:0] s);
        logic signed [DW:0] wide;
        logic [DW-1:0] r;
        logic o;
        r = '0; o = 1'b0;
        case (op)
            4'd0, 4'd1: begin
                wide = $signed({a[DW-1], a}) + $signed({b[DW-1], b});
                r = wide[DW-1:0];
                o = (op == 4'd0) && (wide[DW] != wide[DW-1]);
            end
            4'd2, 4'd3: begin
                wide = $signed({a[DW-1], a}) - $signed({b[DW-1], b});
                r = wide[DW-1:0];
                o = (op == 4'd2) && (wide[DW] != wide[DW-1]);
            end
            4'd4:  r = a & b;
            4'd5:  r = a | b;
            4'd6:  r = a ^ b;
            4'd7:  r = ~(a | b);
            4'd8:  r = b << s;
            4'd9:  r = b >> s;
            4'd10: r = DW'($signed(b) >>> s);
            4'd11: r = {b[15:0], 16'h0000};
            default: r = '0;
        endcase
        return {o, r};
    endfunction

    task automatic apply(input logic [3:0] op, input logic [DW-1:0] a,
                         input logic [DW-1:0] b, input logic [SW-1:0] s);
        @(negedge clk);
        op_sel = op; opd_a = a; opd_b = b; sh_amt = s;
        #1;
    endtask

    task automatic check(input string req, input logic [DW-1:0] exp_r, input logic exp_o);
        n_checks++;
        if (result !== exp_r || ovf_trap !== exp_o) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got result=%h ovf=%b, expected result=%h ovf=%b",
                     req, op_sel, opd_a, opd_b, sh_amt, result, ovf_trap, exp_r, exp_o);
        end
    endtask

    task automatic run(input string req, input logic [3:0] op, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, input logic [SW-1:0] s,
                       input logic [DW-1:0] exp_r, input logic exp_o);
        logic [DW:0] m;
        apply(op, a, b, s);
        check(req, exp_r, exp_o);
        m = model(op, a, b, s);
        check({req, "_model"}, m[DW-1:0], m[DW]);
    endtask

    task automatic t_idle;
        apply(4'd0, '0, '0, '0);
        check("R1 idle", '0, 1'b0);
    endtask

    task automatic t_add;
        run("R1", 4'd0, 32'd5, 32'd7, 0, 32'd12, 1'b0);
        run("R1", 4'd1, 32'hFFFF_FFFF, 32'd1, 0, 32'd0, 1'b0);
        run("R3", 4'd0, 32'h7FFF_FFFF, 32'd1, 0, 32'h8000_0000, 1'b1);
        run("R3", 4'd0, 32'h8000_0000, 32'h8000_0000, 0, 32'd0, 1'b1);
        run("R3", 4'd0, 32'hFFFF_FFFF, 32'd1, 0, 32'd0, 1'b0);
        run("R3", 4'd0, 32'h8000_0000, 32'h7FFF_FFFF, 0, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_sub;
        run("R2", 4'd2, 32'd5, 32'd3, 0, 32'd2, 1'b0);
        run("R2", 4'd3, 32'd0, 32'd1, 0, 32'hFFFF_FFFF, 1'b0);
        run("R4", 4'd2, 32'h8000_0000, 32'd1, 0, 32'h7FFF_FFFF, 1'b1);
        run("R4", 4'd2, 32'd0, 32'h8000_0000, 0, 32'h8000_0000, 1'b1);
        run("R4", 4'd2, 32'hFFFF_FFFF, 32'h8000_0000, 0, 32'h7FFF_FFFF, 1'b0);
        run("R4", 4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 32'h8000_0000, 1'b1);
    endtask

    task automatic t_unsigned_wrap;
        run("R5", 4'd1, 32'h7FFF_FFFF, 32'd1, 0, 32'h8000_0000, 1'b0);
        run("R5", 4'd1, 32'h8000_0000, 32'h8000_0000, 0, 32'd0, 1'b0);
        run("R5", 4'd3, 32'h8000_0000, 32'd1, 0, 32'h7FFF_FFFF, 1'b0);
    endtask

    task automatic t_logic;
        run("R6", 4'd4, 32'hF0F0_1234, 32'hFF00_00FF, 0, 32'hF000_0034, 1'b0);
        run("R6", 4'd5, 32'hF0F0_1234, 32'hFF00_00FF, 0, 32'hFFF0_12FF, 1'b0);
        run("R6", 4'd6, 32'hF0F0_1234, 32'hFF00_00FF, 0, 32'h0FF0_12CB, 1'b0);
        run("R6", 4'd7, 32'hF0F0_1234, 32'hFF00_00FF, 0, 32'h000F_ED00, 1'b0);
    endtask

    task automatic t_shift;
        run("R7", 4'd8, 32'h0, 32'h8000_0001, 0,  32'h8000_0001, 1'b0);
        run("R7", 4'd8, 32'h0, 32'h8000_0001, 1,  32'h0000_0002, 1'b0);
        run("R7", 4'd8, 32'h0, 32'h0000_0003, 31, 32'h8000_0000, 1'b0);
        run("R8", 4'd9, 32'h0, 32'h8000_0001, 1,  32'h4000_0000, 1'b0);
        run("R8", 4'd9, 32'h0, 32'hF000_0000, 16, 32'h0000_F000, 1'b0);
        run("R8", 4'd9, 32'h0, 32'hFFFF_FFFF, 31, 32'h0000_0001, 1'b0);
        run("R9", 4'd10, 32'h0, 32'h8000_0000, 4,  32'hF800_0000, 1'b0);
        run("R9", 4'd10, 32'h0, 32'h8000_0000, 31, 32'hFFFF_FFFF, 1'b0);
        run("R9", 4'd10, 32'h0, 32'h7000_0000, 8,  32'h0070_0000, 1'b0);
    endtask

    task automatic t_lui;
        run("R10", 4'd11, 32'h0, 32'h1234_ABCD, 0, 32'hABCD_0000, 1'b0);
        run("R10", 4'd11, 32'hFFFF_FFFF, 32'h1234_ABCD, 31, 32'hABCD_0000, 1'b0);
        run("R10", 4'd11, 32'h8000_0000, 32'hFFFF_0000, 7, 32'h0000_0000, 1'b0);
    endtask

    task automatic t_unused;
        for (int op = 12; op < 16; op++) begin
            run("R12", 4'(op), 32'h7FFF_FFFF, 32'd1, 5, 32'd0, 1'b0);
        end
    endtask

    task automatic t_sweep;
        logic [DW-1:0] lfsr = 32'hACE1_1234;
        logic [DW-1:0] a, b;
        logic [DW:0] m;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = lfsr;
            apply(4'(i % 16), a, b, SW'(i * 7));
            m = model(op_sel, a, b, sh_amt);
            check((op_sel >= 4'd12) ? "R12 sweep" : "R11 sweep", m[DW-1:0], m[DW]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_add();
        t_sub();
        t_unsigned_wrap();
        t_logic();
        t_shift();
        t_lui();
        t_unused();
        t_sweep();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion within %0d cycles", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule